// File: doc/BRIEF.md
# Single-Slope Conversion Averager

This block is the digital back end of one readout unit built around a single-slope converter. A binary count runs once per ramp in shared logic. That count is spread across the chip in Gray code and reaches this block on `grayCnt`. The analog comparator of the unit arrives on `cmpIn`. During each ramp the block takes the Gray code present in the cycle in which the comparator goes from low to high and keeps it. It keeps only the bits inside the programmed conversion depth and turns them into binary. It then adds the result to a wide running sum.

One level is converted 1, 2, 4 or 8 times. When the last conversion of that level ends, the sum is shifted right by the base-2 logarithm of the sample count. This gives the average, which is published with a one-cycle done strobe. Levels come in pairs. After reset the first level is the reset level and the next is the signal level, and the order keeps alternating. The two results appear on separate 14-bit outputs and are never subtracted inside the block. The depth and the sample count are taken at the start of each level's first ramp.

Top module: `ssadcAccum`

## Requirements
- R1: While reset is asserted and after it is released, `resVal` and `sigVal` read 0 and `resDone` and `sigDone` are low.
- R2: After a ramp starts, the block is armed from the next cycle until the ramp ends. The first cycle in that window where `cmpIn` is high and was low one cycle before becomes the sample. The sample is the `grayCnt` value of that cycle, converted from Gray code to binary, where binary bit i is the XOR of Gray bits i and above.
- R3: The depth d is `cfgDepth` bounded to the range 1..14: a setting of 0 counts as 1 and settings above 14 count as 14. Gray bits at positions d and above are forced to zero before conversion.
- R4: If the comparator does not go from low to high in an armed cycle up to and including the ramp-end cycle, the sample is full scale, 2^d-1.
- R5: A level consists of 2^`cfgSampLog` conversions. Its result is the sum of the samples shifted right by `cfgSampLog`, so any fraction is dropped.
- R6: The sum is 17 bits wide. Eight full-scale 14-bit samples therefore average to 16383 with no wrap.
- R7: Levels alternate. The first level after reset reports on `resVal`/`resDone`, the next on `sigVal`/`sigDone`, and so on.
- R8: The done strobe of a level is high for exactly one cycle, the cycle after the ramp end of that level's last conversion. In that same cycle its value output takes the new result. The other value output is not changed.
- R9: The depth and the sample count are captured at the ramp start that begins a level. Changing them before that level has finished has no effect on it.
- R10: A ramp-end pulse that arrives while no ramp is armed is ignored. Within a single ramp only the first rising comparator edge is used; later edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgDepth | input | 4 | Conversion depth in bits (bounded to 1..14) |
| cfgSampLog | input | 2 | Log2 of the number of conversions per level |
| rampStart | input | 1 | One-cycle pulse when a ramp starts |
| rampEnd | input | 1 | One-cycle pulse when a ramp ends |
| cmpIn | input | 1 | Comparator output, already synchronous |
| grayCnt | input | 14 | Shared Gray-coded ramp count |
| resVal | output | 14 | Averaged reset-level result |
| sigVal | output | 14 | Averaged signal-level result |
| resDone | output | 1 | One-cycle strobe: a new reset result is valid |
| sigDone | output | 1 | One-cycle strobe: a new signal result is valid |

## Verification
An error in the capture state, such as a missed trip or a second trip taken, changes only the sample of the current ramp. It shows up as a wrong average at the end of that level, which can be as much as eight ramps later. A conversion counter or phase bit that has slipped shows up sooner, as a done strobe in the wrong cycle or on the wrong output. The bench therefore runs a cycle-accurate reference model and compares both value outputs and both strobes on every clock. It also checks each level's result against a value worked out by hand.

// File: rtl/ssAccumPkg.sv
package ssAccumPkg;

  // Strobes and levels from control to the datapath
  typedef struct packed {
    logic armed;      // a ramp is in progress
    logic rearm;      // a ramp starts this cycle
    logic clearAcc;   // first ramp of a level starts
    logic addSample;  // a valid ramp end: add the sample
    logic finish;     // this ramp end closes the level
    logic toSig;      // the current level is the signal level
  } accStrobeT;

endpackage

// File: rtl/ssAccumCtrl.sv
module ssAccumCtrl
  import ssAccumPkg::*;
#(
  parameter int MAX_BITS = 14,
  parameter int MAX_LOG  = 3,
  parameter int DEPTH_W  = $clog2(MAX_BITS + 1),
  parameter int LOG_W    = $clog2(MAX_LOG + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DEPTH_W-1:0] cfgDepth,
  input  logic [LOG_W-1:0]   cfgSampLog,
  input  logic               rampStart,
  input  logic               rampEnd,
  output accStrobeT          stb,
  output logic [DEPTH_W-1:0] depthQ,
  output logic [LOG_W-1:0]   logQ
);

  localparam int CNT_W = MAX_LOG;
  localparam int CN_W  = MAX_LOG + 1;

  logic             armed;
  logic             toSig;
  logic [CNT_W-1:0] convCnt;
  logic [CN_W-1:0]  cntNext;
  logic             lastConv;
  logic             levelStart;
  logic             endOk;
  logic [DEPTH_W-1:0] depthBounded;
  logic [LOG_W-1:0]   logBounded;

  always_comb begin
    if (cfgDepth == '0) begin
      depthBounded = DEPTH_W'(1);
    end else if (cfgDepth > DEPTH_W'(MAX_BITS)) begin
      depthBounded = DEPTH_W'(MAX_BITS);
    end else begin
      depthBounded = cfgDepth;
    end
    if (cfgSampLog > LOG_W'(MAX_LOG)) begin
      logBounded = LOG_W'(MAX_LOG);
    end else begin
      logBounded = cfgSampLog;
    end
  end

  always_comb begin
    cntNext    = {1'b0, convCnt} + CN_W'(1);
    lastConv   = (cntNext == (CN_W'(1) << logQ));
    levelStart = rampStart && (convCnt == '0);
    endOk      = rampEnd && armed;

    stb.armed     = armed;
    stb.rearm     = rampStart;
    stb.clearAcc  = levelStart;
    stb.addSample = endOk;
    stb.finish    = endOk && lastConv;
    stb.toSig     = toSig;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      toSig   <= 1'b0;
      convCnt <= '0;
      depthQ  <= DEPTH_W'(MAX_BITS);
      logQ    <= '0;
    end else begin
      if (rampStart) begin
        armed <= 1'b1;
      end else if (rampEnd) begin
        armed <= 1'b0;
      end

      if (levelStart) begin
        depthQ <= depthBounded;
        logQ   <= logBounded;
      end

      if (endOk) begin
        if (lastConv) begin
          convCnt <= '0;
          toSig   <= !toSig;
        end else begin
          convCnt <= cntNext[CNT_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/ssAccumPath.sv
module ssAccumPath
  import ssAccumPkg::*;
#(
  parameter int MAX_BITS = 14,
  parameter int MAX_LOG  = 3,
  parameter int DEPTH_W  = $clog2(MAX_BITS + 1),
  parameter int LOG_W    = $clog2(MAX_LOG + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  accStrobeT           stb,
  input  logic [DEPTH_W-1:0]  depthQ,
  input  logic [LOG_W-1:0]    logQ,
  input  logic                cmpIn,
  input  logic [MAX_BITS-1:0] grayCnt,
  output logic [MAX_BITS-1:0] resVal,
  output logic [MAX_BITS-1:0] sigVal,
  output logic                resDone,
  output logic                sigDone
);

  localparam int ACC_W = MAX_BITS + MAX_LOG;

  logic                cmpPrev;
  logic                captured;
  logic                tripNow;
  logic [MAX_BITS-1:0] depthMask;
  logic [MAX_BITS-1:0] latchGray;
  logic [MAX_BITS-1:0] selGray;
  logic [MAX_BITS-1:0] binConv;
  logic [MAX_BITS-1:0] sampleBin;
  logic [ACC_W-1:0]    accSum;
  logic [ACC_W-1:0]    sumNext;
  logic [MAX_BITS-1:0] avgBits;

  // depth mask: bit i kept when i < depth
  for (genvar i = 0; i < MAX_BITS; i++) begin : gMask
    assign depthMask[i] = (depthQ > DEPTH_W'(i));
  end

  assign tripNow = stb.armed && !captured && cmpIn && !cmpPrev;
  assign selGray = captured ? latchGray : (grayCnt & depthMask);

  // Gray to binary: prefix XOR from the top bit down
  assign binConv[MAX_BITS-1] = selGray[MAX_BITS-1];
  for (genvar i = MAX_BITS - 2; i >= 0; i--) begin : gG2b
    assign binConv[i] = binConv[i+1] ^ selGray[i];
  end

  assign sampleBin = (captured || tripNow) ? binConv : depthMask;
  assign sumNext   = accSum + ACC_W'(sampleBin);
  assign avgBits   = MAX_BITS'(sumNext >> logQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpPrev   <= 1'b0;
      captured  <= 1'b0;
      latchGray <= '0;
      accSum    <= '0;
      resVal    <= '0;
      sigVal    <= '0;
      resDone   <= 1'b0;
      sigDone   <= 1'b0;
    end else begin
      cmpPrev <= cmpIn;

      if (stb.rearm) begin
        captured <= 1'b0;
      end else if (tripNow) begin
        captured  <= 1'b1;
        latchGray <= grayCnt & depthMask;
      end

      if (stb.clearAcc) begin
        accSum <= '0;
      end else if (stb.addSample) begin
        accSum <= sumNext;
      end

      resDone <= stb.finish && !stb.toSig;
      sigDone <= stb.finish && stb.toSig;
      if (stb.finish) begin
        if (stb.toSig) begin
          sigVal <= avgBits;
        end else begin
          resVal <= avgBits;
        end
      end
    end
  end

endmodule

// File: rtl/ssadcAccum.sv
module ssadcAccum
  import ssAccumPkg::*;
#(
  parameter int MAX_BITS = 14,
  parameter int MAX_LOG  = 3,
  parameter int DEPTH_W  = $clog2(MAX_BITS + 1),
  parameter int LOG_W    = $clog2(MAX_LOG + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DEPTH_W-1:0]  cfgDepth,
  input  logic [LOG_W-1:0]    cfgSampLog,
  input  logic                rampStart,
  input  logic                rampEnd,
  input  logic                cmpIn,
  input  logic [MAX_BITS-1:0] grayCnt,
  output logic [MAX_BITS-1:0] resVal,
  output logic [MAX_BITS-1:0] sigVal,
  output logic                resDone,
  output logic                sigDone
);

  accStrobeT          stb;
  logic [DEPTH_W-1:0] depthQ;
  logic [LOG_W-1:0]   logQ;

  ssAccumCtrl #(
    .MAX_BITS(MAX_BITS), .MAX_LOG(MAX_LOG), .DEPTH_W(DEPTH_W), .LOG_W(LOG_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgDepth(cfgDepth), .cfgSampLog(cfgSampLog),
    .rampStart(rampStart), .rampEnd(rampEnd),
    .stb(stb), .depthQ(depthQ), .logQ(logQ)
  );

  ssAccumPath #(
    .MAX_BITS(MAX_BITS), .MAX_LOG(MAX_LOG), .DEPTH_W(DEPTH_W), .LOG_W(LOG_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .depthQ(depthQ), .logQ(logQ),
    .cmpIn(cmpIn), .grayCnt(grayCnt),
    .resVal(resVal), .sigVal(sigVal), .resDone(resDone), .sigDone(sigDone)
  );

endmodule

// File: rtl/ssAccumChk.sv
module ssAccumChk #(
  parameter int MAX_BITS = 14
) (
  input logic                clk,
  input logic                rstN,
  input logic                rampEnd,
  input logic [MAX_BITS-1:0] resVal,
  input logic [MAX_BITS-1:0] sigVal,
  input logic                resDone,
  input logic                sigDone
);

  logic expectSig;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expectSig <= 1'b0;
    end else if (resDone || sigDone) begin
      expectSig <= !expectSig;
    end
  end

  assert_done_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(resDone && sigDone));

  assert_res_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    resDone |-> !expectSig);

  assert_sig_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    sigDone |-> expectSig);

  assert_res_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    resDone |=> !resDone);

  assert_sig_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    sigDone |=> !sigDone);

  assert_done_after_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    (resDone || sigDone) |-> $past(rampEnd));

  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !resDone |-> $stable(resVal));

  assert_sig_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !sigDone |-> $stable(sigVal));

endmodule

bind ssadcAccum ssAccumChk u_chk (
  .clk(clk), .rstN(rstN), .rampEnd(rampEnd),
  .resVal(resVal), .sigVal(sigVal), .resDone(resDone), .sigDone(sigDone)
);

// File: tb/test_ssadcAccum.sv
module test_ssadcAccum;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cfgDepth = 4'd14;
  logic [1:0]  cfgSampLog = 2'd0;
  logic        rampStart = 1'b0;
  logic        rampEnd = 1'b0;
  logic        cmpIn = 1'b0;
  logic [13:0] grayCnt = '0;
  logic [13:0] resVal, sigVal;
  logic        resDone, sigDone;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit lastResDone, lastSigDone;

  // reference model state
  bit mArmed, mCap, mPrev, mPhase, tripNow, expResDone, expSigDone;
  int mLatch, mSum, mCnt, mLog, mMask, oldCnt, v, d, expRes, expSig;

  always #4 clk = !clk;

  ssadcAccum i_ssadcAccum (
    .clk(clk), .rstN(rstN), .cfgDepth(cfgDepth), .cfgSampLog(cfgSampLog),
    .rampStart(rampStart), .rampEnd(rampEnd), .cmpIn(cmpIn), .grayCnt(grayCnt),
    .resVal(resVal), .sigVal(sigVal), .resDone(resDone), .sigDone(sigDone)
  );

  function automatic int grayToBin(input int g);
    int r = 0;
    int acc = 0;
    for (int i = 13; i >= 0; i--) begin
      acc = acc ^ ((g >> i) & 1);
      r = r | (acc << i);
    end
    return r;
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // cycle-accurate behavioural reference
  always @(posedge clk) begin
    if (!rstN) begin
      mArmed = 0; mCap = 0; mPrev = 0; mPhase = 0; mLatch = 0; mSum = 0;
      mCnt = 0; mLog = 0; mMask = 16383; expRes = 0; expSig = 0;
      expResDone = 0; expSigDone = 0;
    end else begin
      expResDone = 0;
      expSigDone = 0;
      oldCnt = mCnt;
      tripNow = mArmed && !mCap && cmpIn && !mPrev;
      if (rampEnd && mArmed) begin
        if (mCap) v = grayToBin(mLatch);
        else if (tripNow) v = grayToBin(int'(grayCnt) & mMask);
        else v = mMask;
        mSum += v;
        mCnt++;
        if (mCnt == (1 << mLog)) begin
          if (mPhase) begin expSig = mSum >> mLog; expSigDone = 1; end
          else begin expRes = mSum >> mLog; expResDone = 1; end
          mPhase = !mPhase;
          mCnt = 0;
        end
      end
      if (tripNow) begin mCap = 1; mLatch = int'(grayCnt) & mMask; end
      if (rampStart) begin
        mArmed = 1; mCap = 0;
        if (oldCnt == 0) begin
          mSum = 0;
          d = (cfgDepth == 0) ? 1 : ((cfgDepth > 14) ? 14 : int'(cfgDepth));
          mMask = (1 << d) - 1;
          mLog = int'(cfgSampLog);
        end
      end else if (rampEnd) begin
        mArmed = 0;
      end
      mPrev = cmpIn;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(int'(resVal), expRes, "R5 model resVal");
      check(int'(sigVal), expSig, "R5 model sigVal");
      check(int'(resDone), int'(expResDone), "R8 model resDone");
      check(int'(sigDone), int'(expSigDone), "R8 model sigDone");
    end
  end

  // one ramp: start pulse, count from base, comparator rises at tripAt (<0: never)
  task automatic conv(input int base, input int tripAt, input bit glitch, input int len);
    int b;
    rampStart = 1; cmpIn = 0; grayCnt = 14'(base ^ (base >> 1));
    @(negedge clk);
    rampStart = 0;
    for (int i = 0; i < len; i++) begin
      b = base + i;
      grayCnt = 14'(b ^ (b >> 1));
      if (tripAt < 0) cmpIn = 0;
      else if (glitch) cmpIn = (i == tripAt) || (i >= tripAt + 3);
      else cmpIn = (i >= tripAt);
      @(negedge clk);
    end
    rampEnd = 1;
    @(negedge clk);
    lastResDone = resDone;
    lastSigDone = sigDone;
    rampEnd = 0; cmpIn = 0;
    @(negedge clk);
  endtask

  task automatic sampleAt(input int val);
    conv(val - 1, 1, 1'b0, 3);
  endtask

  task automatic noTrip();
    conv(0, -1, 1'b0, 4);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(int'(resVal), 0, "R1 reset resVal");
    check(int'(sigVal), 0, "R1 reset sigVal");
    check(int'(resDone | sigDone), 0, "R1 reset strobes");
    rstN = 1;
    @(negedge clk);
    check(int'(resVal), 0, "R1 after release resVal");

    // L1 reset level: depth 10, four samples, floor average
    cfgDepth = 10; cfgSampLog = 2;
    sampleAt(100); sampleAt(101); sampleAt(102); sampleAt(104);
    check(int'(lastResDone), 1, "R8 reset done strobe");
    check(int'(resVal), 101, "R2 R5 four-sample average");

    // L2 signal level: single sample
    cfgSampLog = 0;
    sampleAt(500);
    check(int'(lastSigDone), 1, "R7 second level is signal");
    check(int'(sigVal), 500, "R2 single conversion");
    check(int'(resVal), 101, "R8 reset result holds");

    // L3 reset level: no trip at depth 8
    cfgDepth = 8; cfgSampLog = 1;
    noTrip(); noTrip();
    check(int'(resVal), 255, "R4 full scale at depth 8");

    // L4 signal level: bits above depth 6 masked
    cfgDepth = 6; cfgSampLog = 0;
    sampleAt(69);
    check(int'(sigVal), 58, "R3 gray bits above depth masked");

    // L5 reset level: depth setting 15 bounded to 14, eight full-scale samples
    cfgDepth = 15; cfgSampLog = 3;
    for (int k = 0; k < 8; k++) noTrip();
    check(int'(resVal), 16383, "R6 eight full-scale samples no wrap");

    // L6 signal level: config changed mid-level
    cfgDepth = 12; cfgSampLog = 1;
    sampleAt(1000);
    check(int'(lastSigDone), 0, "R9 level not closed after first of two");
    cfgDepth = 4; cfgSampLog = 0;
    sampleAt(1002);
    check(int'(lastSigDone), 1, "R9 closes after latched count");
    check(int'(sigVal), 1001, "R9 latched depth and count used");

    // stray ramp end while idle
    rampEnd = 1;
    @(negedge clk);
    rampEnd = 0;
    check(int'(resDone | sigDone), 0, "R10 stray ramp end no strobe");
    @(negedge clk);

    // L7 reset level: comparator glitches, first edge wins
    cfgDepth = 14; cfgSampLog = 0;
    conv(2000, 3, 1'b1, 9);
    check(int'(lastResDone), 1, "R10 stray end not counted");
    check(int'(resVal), 2003, "R10 first comparator edge used");

    // L8 signal level: depth 0 bounded to 1
    cfgDepth = 0; cfgSampLog = 0;
    noTrip();
    check(int'(sigVal), 1, "R3 depth 0 treated as 1");

    // L9 reset level: eight samples, fraction dropped
    cfgDepth = 14; cfgSampLog = 3;
    for (int k = 10; k < 18; k++) sampleAt(k);
    check(int'(resVal), 13, "R5 eight-sample floor average");
    check(int'(sigVal), 1, "R8 signal result holds");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule